// File: doc/BRIEF.md
# Jittered Switching Oscillator

This block times the switching cycles of a current-mode PWM controller. It counts system clocks to make a fixed-frequency switching period, selected from two nominal frequencies by a plain option pin, and sweeps that period slowly along a triangle so that the switching energy spreads over a band instead of a single line. Each switching cycle starts with a one-clock start pulse, which sets the output latch. A window signal marks the part of the cycle in which the switch may stay on, 80% of the current period. A one-clock strobe then tells the external compensation ramp to go back to zero.

The sweep is a signed fixed-point offset, in counts, that moves by a fixed step once per switching cycle and turns around at plus and minus the jitter depth. A new period, window width and option are taken only when a cycle ends, so a cycle that is already running is never shortened or stretched. The block has no data stream and no handshake. All pins are plain control and timing signals.

Top module: `osc_jitter`

## Requirements
- R1: While `rst_n` is low, `cyc_start`, `duty_win` and `ramp_rst` are low. The first rising edge with reset released begins cycle zero, so `cyc_start` is high in the clock that follows that edge and low in the clock before it.
- R2: `cyc_start` is high for exactly one clock at the start of each switching cycle. The cycle lasts P = NOM − floor(A / 2^FRAC_W) clocks, where NOM = CLK_HZ / f (integer division) and A is the sweep offset in force for that cycle.
- R3: The sweep offset A is 0 in the first cycle after reset, with the direction set to upward (period shrinking, frequency rising). At each later cycle boundary it moves by STEP in its direction. If the result reaches or passes +LIM (going up) or −LIM (going down), A is clamped to that limit and the direction reverses.
- R4: DEV = NOM·JIT_PERMIL/1000 and LIM = DEV·2^FRAC_W. HALF = f·MOD_US/2,000,000 cycles, and STEP = max(1, 2·LIM/HALF), all with integer division. The sweep therefore crosses both ends of its range once per modulation period.
- R5: `duty_win` is high for the first W = P·DUTY_PCT/100 clocks of each cycle, including the `cyc_start` clock, and low for the remaining P − W clocks.
- R6: `ramp_rst` is high for exactly one clock per cycle, the clock at index W counted from 0 at `cyc_start`. This is the first clock after the window closes. It never coincides with `cyc_start`.
- R7: `opt_fast` = 0 selects f = F_A and `opt_fast` = 1 selects f = F_B. The pin is sampled only on the edge that begins a cycle. A change in the middle of a cycle has no effect on that cycle's length or window.
- R8: When the sampled option differs from the option of the cycle just ended, the new cycle restarts the sweep with A = 0 and the direction upward.
- R9: Every cycle length lies between min(NOM − DEV) and max(NOM + DEV) over the two options, and for each option the sweep reaches both NOM − DEV and NOM + DEV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_fast | input | 1 | Frequency option: 0 selects F_A, 1 selects F_B |
| cyc_start | output | 1 | One-clock pulse at the start of each switching cycle |
| duty_win | output | 1 | High during the allowed on-time window of the cycle |
| ramp_rst | output | 1 | One-clock strobe that returns the compensation ramp to zero |

## Verification
The properties assume parameters for which every period is at least two clocks and the window is always shorter than the period. They also assume that `opt_fast` is a synchronous level, which may change in any clock. The stimulus changes `opt_fast` just after a rising edge, at random clock counts that fall mostly in the middle of cycles, and it holds each option long enough for a full modulation sweep. This lets both clamps and the restart on an option change be reached. A mid-run reset checks that the sweep and the option are re-initialised.

// File: rtl/osc_jit_pkg.sv
package osc_jit_pkg;

  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_dir_e;

  // clocks in one nominal switching period
  function automatic int base_count(input int clk_hz, input int f_hz);
    return clk_hz / f_hz;
  endfunction

  // jitter depth in whole clocks
  function automatic int dev_count(input int nom, input int permil);
    return (nom * permil) / 1000;
  endfunction

  // fixed-point step per switching cycle so that one full swing takes half a modulation period
  function automatic int step_fx(input int dev, input int f_hz, input int mod_us, input int frac_w);
    longint half;
    longint s;
    half = (longint'(f_hz) * longint'(mod_us)) / 64'sd2000000;
    if (half < 1) half = 1;
    s = (longint'(2 * dev) <<< frac_w) / half;
    if (s < 1) s = 1;
    return int'(s);
  endfunction

endpackage

// File: rtl/osc_sweep.sv
module osc_sweep
  import osc_jit_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    restart,
  input  logic signed [ACC_W-1:0] step,
  input  logic signed [ACC_W-1:0] lim,
  output logic signed [ACC_W-1:0] acc_next
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] dif;
  sweep_dir_e              dir_q;
  sweep_dir_e              dir_d;

  always_comb begin
    sum      = acc_q + step;
    dif      = acc_q - step;
    acc_next = acc_q;
    dir_d    = dir_q;
    if (restart) begin
      acc_next = '0;
      dir_d    = SWEEP_UP;
    end else if (adv) begin
      if (dir_q == SWEEP_UP) begin
        if (sum >= lim) begin
          acc_next = lim;
          dir_d    = SWEEP_DOWN;
        end else begin
          acc_next = sum;
        end
      end else begin
        if (dif <= -lim) begin
          acc_next = -lim;
          dir_d    = SWEEP_UP;
        end else begin
          acc_next = dif;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      dir_q <= SWEEP_UP;
    end else begin
      acc_q <= acc_next;
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/osc_period.sv
module osc_period #(
  parameter int NOM_A    = 100,
  parameter int NOM_B    = 65,
  parameter int DUTY_PCT = 80,
  parameter int FRAC_W   = 8,
  parameter int ACC_W    = 16,
  parameter int CNT_W    = 8
) (
  input  logic                    sel_b,
  input  logic signed [ACC_W-1:0] acc,
  output logic        [CNT_W-1:0] period,
  output logic        [CNT_W-1:0] width
);

  logic signed [ACC_W-1:0] ofs;
  logic signed [31:0]      ofs32;
  logic signed [31:0]      base;
  logic signed [31:0]      per32;
  logic signed [31:0]      wid32;
  logic                    unused_hi;

  always_comb begin
    ofs    = acc >>> FRAC_W;
    ofs32  = 32'(ofs);
    base   = sel_b ? 32'(NOM_B) : 32'(NOM_A);
    per32  = base - ofs32;
    wid32  = (per32 * DUTY_PCT) / 100;
    period = per32[CNT_W-1:0];
    width  = wid32[CNT_W-1:0];
  end

  assign unused_hi = ^{per32[31:CNT_W], wid32[31:CNT_W]};

endmodule

// File: rtl/osc_cycle_timer.sv
module osc_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_d,
  input  logic [CNT_W-1:0] width_d,
  output logic             bnd,
  output logic             live,
  output logic             cyc_start,
  output logic             duty_win,
  output logic             ramp_rst
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] wid_q;
  logic             live_q;

  assign bnd  = !live_q || (cnt_q == per_q - CNT_W'(1));
  assign live = live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      wid_q  <= '0;
      live_q <= 1'b0;
    end else if (bnd) begin
      cnt_q  <= '0;
      per_q  <= period_d;
      wid_q  <= width_d;
      live_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign cyc_start = live_q && (cnt_q == '0);
  assign duty_win  = live_q && (cnt_q < wid_q);
  assign ramp_rst  = live_q && (cnt_q == wid_q);

endmodule

// File: rtl/osc_jitter.sv
module osc_jitter
  import osc_jit_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int F_A        = 65_000,
  parameter int F_B        = 100_000,
  parameter int MOD_US     = 6_000,
  parameter int JIT_PERMIL = 75,
  parameter int DUTY_PCT   = 80,
  parameter int FRAC_W     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic opt_fast,
  output logic cyc_start,
  output logic duty_win,
  output logic ramp_rst
);

  localparam int NOM_A  = base_count(CLK_HZ, F_A);
  localparam int NOM_B  = base_count(CLK_HZ, F_B);
  localparam int DEV_A  = dev_count(NOM_A, JIT_PERMIL);
  localparam int DEV_B  = dev_count(NOM_B, JIT_PERMIL);
  localparam int STEP_A = step_fx(DEV_A, F_A, MOD_US, FRAC_W);
  localparam int STEP_B = step_fx(DEV_B, F_B, MOD_US, FRAC_W);
  localparam int LIM_A  = DEV_A * (1 << FRAC_W);
  localparam int LIM_B  = DEV_B * (1 << FRAC_W);
  localparam int MAX_P  = (NOM_A + DEV_A > NOM_B + DEV_B) ? NOM_A + DEV_A : NOM_B + DEV_B;
  localparam int MIN_P  = (NOM_A - DEV_A < NOM_B - DEV_B) ? NOM_A - DEV_A : NOM_B - DEV_B;
  localparam int DEV_MX = (DEV_A > DEV_B) ? DEV_A : DEV_B;
  localparam int CNT_W  = $clog2(MAX_P + 1);
  localparam int ACC_W  = $clog2(DEV_MX + 1) + FRAC_W + 2;

  logic                    bnd;
  logic                    live;
  logic                    opt_q;
  logic                    opt_chg;
  logic                    restart;
  logic                    adv;
  logic signed [ACC_W-1:0] step_sel;
  logic signed [ACC_W-1:0] lim_sel;
  logic signed [ACC_W-1:0] acc_next;
  logic        [CNT_W-1:0] period_d;
  logic        [CNT_W-1:0] width_d;

  // option of the running cycle; taken only on a boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_q <= 1'b0;
    else if (bnd) opt_q <= opt_fast;
  end

  assign opt_chg  = (opt_fast != opt_q);
  assign restart  = bnd && (!live || opt_chg);
  assign adv      = bnd && live && !opt_chg;
  assign step_sel = opt_q ? ACC_W'(STEP_B) : ACC_W'(STEP_A);
  assign lim_sel  = opt_q ? ACC_W'(LIM_B)  : ACC_W'(LIM_A);

  osc_sweep #(
    .ACC_W(ACC_W)
  ) u_sweep (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .restart (restart),
    .step    (step_sel),
    .lim     (lim_sel),
    .acc_next(acc_next)
  );

  osc_period #(
    .NOM_A   (NOM_A),
    .NOM_B   (NOM_B),
    .DUTY_PCT(DUTY_PCT),
    .FRAC_W  (FRAC_W),
    .ACC_W   (ACC_W),
    .CNT_W   (CNT_W)
  ) u_period (
    .sel_b (opt_fast),
    .acc   (acc_next),
    .period(period_d),
    .width (width_d)
  );

  osc_cycle_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_d (period_d),
    .width_d  (width_d),
    .bnd      (bnd),
    .live     (live),
    .cyc_start(cyc_start),
    .duty_win (duty_win),
    .ramp_rst (ramp_rst)
  );

endmodule

// File: rtl/osc_jitter_chk.sv
module osc_jitter_chk #(
  parameter int MIN_P = 2,
  parameter int MAX_P = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cyc_start,
  input logic duty_win,
  input logic ramp_rst
);

  int   gap;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (cyc_start) begin
      gap  <= 1;
      seen <= 1'b1;
    end else if (gap < MAX_P + 1) begin
      gap  <= gap + 1;
    end
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_start && ramp_rst));

  // R5
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> duty_win);

  // R6
  ramp_after_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_rst |-> ($past(duty_win) && !duty_win));

  // R6
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(duty_win) |-> ramp_rst);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);

  // R9
  period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && seen) |-> (gap >= MIN_P && gap <= MAX_P));

  // R9
  period_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && seen) |-> (gap < MAX_P));

endmodule

bind osc_jitter osc_jitter_chk #(
  .MIN_P(MIN_P),
  .MAX_P(MAX_P)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_start(cyc_start),
  .duty_win (duty_win),
  .ramp_rst (ramp_rst)
);

// File: tb/sim_osc_jitter.sv
`timescale 1ns/1ps
module sim_osc_jitter;

  localparam int CLK_HZ = 6_500_000;
  localparam int FA     = 65_000;
  localparam int FB     = 100_000;
  localparam int MODUS  = 6_000;
  localparam int PERMIL = 75;
  localparam int DUTY   = 80;
  localparam int FRAC   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opt_fast = 1'b0;
  logic cyc_start, duty_win, ramp_rst;

  always #2.5 clk = ~clk;

  osc_jitter #(
    .CLK_HZ(CLK_HZ), .F_A(FA), .F_B(FB), .MOD_US(MODUS),
    .JIT_PERMIL(PERMIL), .DUTY_PCT(DUTY), .FRAC_W(FRAC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .opt_fast(opt_fast),
    .cyc_start(cyc_start), .duty_win(duty_win), .ramp_rst(ramp_rst)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected constants from the requirement formulas
  function automatic int e_nom(input bit o);
    return CLK_HZ / (o ? FB : FA);
  endfunction
  function automatic int e_dev(input bit o);
    return (e_nom(o) * PERMIL) / 1000;
  endfunction
  function automatic int e_lim(input bit o);
    return e_dev(o) * 256;
  endfunction
  function automatic int e_step(input bit o);
    int half, s;
    half = ((o ? FB : FA) * MODUS) / 2000000;
    s = (2 * e_lim(o)) / half;
    return (s < 1) ? 1 : s;
  endfunction
  function automatic int floor_div(input int a);
    if (a >= 0) return a / 256;
    return -((-a + 255) / 256);
  endfunction

  // model and observation state
  int  m_acc, m_per, m_wid, pos, duty_cnt, ramp_cnt, ramp_at, rel_cnt;
  bit  m_dn, m_opt, m_valid, fresh, opt_prev, start_duty;
  int  mn [2];
  int  mx [2];

  initial begin
    fresh = 1'b1; m_valid = 1'b0; rel_cnt = 0; pos = 0;
    mn[0] = 1 << 30; mn[1] = 1 << 30; mx[0] = 0; mx[1] = 0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1: quiet during reset
      chk(!cyc_start && !duty_win && !ramp_rst, "R1 reset outputs",
          {29'd0, cyc_start, duty_win, ramp_rst}, 0);
      fresh = 1'b1; m_valid = 1'b0; rel_cnt = 0;
    end else begin
      rel_cnt++;
      if (rel_cnt == 1) chk(!cyc_start, "R1 no start before first edge", int'(cyc_start), 0);
      if (rel_cnt == 2) chk(cyc_start, "R1 start after first edge", int'(cyc_start), 1);
      if (cyc_start) begin
        if (m_valid) begin
          chk(pos == m_per, "R2 R3 R7 cycle length", pos, m_per);
          chk(duty_cnt == m_wid && start_duty, "R5 window clocks", duty_cnt, m_wid);
          chk(ramp_cnt == 1 && ramp_at == m_wid, "R6 ramp strobe index", ramp_at, m_wid);
          if (pos < mn[m_opt]) mn[m_opt] = pos;
          if (pos > mx[m_opt]) mx[m_opt] = pos;
        end
        if (fresh || opt_prev != m_opt) begin
          // R8: restart of the sweep
          m_opt = opt_prev; m_acc = 0; m_dn = 1'b0;
        end else if (!m_dn) begin
          m_acc = m_acc + e_step(m_opt);
          if (m_acc >= e_lim(m_opt)) begin m_acc = e_lim(m_opt); m_dn = 1'b1; end
        end else begin
          m_acc = m_acc - e_step(m_opt);
          if (m_acc <= -e_lim(m_opt)) begin m_acc = -e_lim(m_opt); m_dn = 1'b0; end
        end
        fresh = 1'b0;
        m_per = e_nom(m_opt) - floor_div(m_acc);
        m_wid = (m_per * DUTY) / 100;
        m_valid = 1'b1;
        pos = 1;
        duty_cnt = duty_win ? 1 : 0;
        start_duty = duty_win;
        ramp_cnt = ramp_rst ? 1 : 0;
        ramp_at = ramp_rst ? 0 : -1;
      end else if (m_valid) begin
        pos++;
        if (duty_win) duty_cnt++;
        if (ramp_rst) begin ramp_cnt++; ramp_at = pos - 1; end
        if (pos == 3 * e_nom(1'b0)) chk(1'b0, "R2 cycle never ended", pos, m_per);
      end
    end
    opt_prev = opt_fast;
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", wd, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(7741));
    wait_clk(6);
    rst_n = 1'b1;

    // option A held across a full sweep: both clamps reached (R4, R9)
    wait_clk(40000);
    chk(mn[0] == e_nom(1'b0) - e_dev(1'b0), "R4 R9 option A shortest", mn[0], e_nom(1'b0) - e_dev(1'b0));
    chk(mx[0] == e_nom(1'b0) + e_dev(1'b0), "R4 R9 option A longest", mx[0], e_nom(1'b0) + e_dev(1'b0));

    // switch mid-cycle to option B (R7, R8)
    wait_clk(37);
    opt_fast = 1'b1;
    wait_clk(40000);
    chk(mn[1] == e_nom(1'b1) - e_dev(1'b1), "R4 R9 option B shortest", mn[1], e_nom(1'b1) - e_dev(1'b1));
    chk(mx[1] == e_nom(1'b1) + e_dev(1'b1), "R4 R9 option B longest", mx[1], e_nom(1'b1) + e_dev(1'b1));

    // random option changes, some back-to-back within one cycle
    for (int i = 0; i < 24; i++) begin
      wait_clk(($urandom % 2500) + 1);
      opt_fast = ~opt_fast;
      if (($urandom % 4) == 0) begin
        wait_clk(($urandom % 20) + 1);
        opt_fast = ~opt_fast;
      end
    end

    // reset in the middle of a run restarts everything (R1, R3)
    wait_clk(53);
    rst_n = 1'b0;
    opt_fast = 1'b1;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(3000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule